// File: doc/BRIEF.md
# Translation Miss Tracking Table with Walk Merging

This block sits between the units that miss in the translation buffers and a pool of page table walkers. It holds a small, parameterised number of tracking slots, one per walker. Each incoming miss carries a requester number, a virtual page number and an address-space tag. The block compares the miss against every occupied slot. If the page and the address space both match an occupied slot, the requester joins that slot's list of waiters. If nothing matches, the miss takes the lowest-numbered free slot, and the block tells the walker with the same index to begin a walk.

When every slot is occupied, the block drops its ready signal. Every miss then waits, including a miss that would have merged, until a walk finishes. When the walker reports completion for a slot, the block releases the whole waiter set of that slot in one cycle as a bit mask indexed by requester number, and the slot becomes free.

Top module: `walk_mshr`

## Requirements
- R1: After reset every slot is free, `miss_ready_o` is 1, and `walk_start_valid_o` and `wake_valid_o` are 0.
- R2: An accepted miss that matches no occupied slot claims a free slot. In the next cycle `walk_start_valid_o` pulses for one cycle with that slot index and the miss's page number and address-space tag.
- R3: An accepted miss whose page number and address-space tag both equal those of an occupied slot sets bit `miss_rid_i` of that slot's waiter mask and starts no walk.
- R4: A miss with the same page number as an occupied slot but a different address-space tag is not merged; it starts a walk of its own.
- R5: While all slots are occupied, `miss_ready_o` is 0 and no miss is accepted. It returns to 1 in the cycle after a completion frees a slot.
- R6: When `walk_done_valid_i` is 1 for an occupied slot, in the next cycle `wake_valid_o` pulses with `wake_mask_o` holding every waiter of that slot (bit n = requester n), and the slot becomes free.
- R7: A miss accepted in the same cycle as the completion of the walk it matches is not merged; it claims another free slot and starts a new walk.
- R8: A miss to a page whose walk has already finished and been freed starts a new walk.
- R9: A completion reported for a free slot produces no wake pulse.
- R10: When several slots are free, a new walk takes the lowest-numbered one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| miss_valid_i | input | 1 | A translation miss is presented |
| miss_ready_o | output | 1 | At least one slot is free; the miss is accepted when valid and ready |
| miss_rid_i | input | RID_W (4) | Requester number of the miss |
| miss_vpn_i | input | VPN_W (36) | Virtual page number |
| miss_asid_i | input | ASID_W (12) | Address-space tag |
| walk_start_valid_o | output | 1 | One-cycle pulse: the walker `walk_start_slot_o` must begin a walk |
| walk_start_slot_o | output | SLOT_W (2) | Slot, and walker, index of the new walk |
| walk_start_vpn_o | output | VPN_W (36) | Page number to walk |
| walk_start_asid_o | output | ASID_W (12) | Address-space tag to walk |
| walk_done_valid_i | input | 1 | A walker reports completion |
| walk_done_slot_i | input | SLOT_W (2) | Slot whose walk completed |
| wake_valid_o | output | 1 | One-cycle pulse releasing waiters |
| wake_mask_o | output | NUM_REQ (16) | Requesters released, bit n = requester n |

## Verification
Both result pulses are registered. A walk start appears in the cycle after the clock edge that accepted its miss, and a wake appears in the cycle after the edge that sampled the completion. `miss_ready_o` reflects slot occupancy with no delay. So a slot freed at an edge shows as ready just after that edge. Stimulus is applied just after a rising edge. The monitor samples on the falling edge and pairs each start or wake pulse, in order, with the expectation the driver queued for the edge before it. Any pulse with no queued expectation counts as a mismatch. This is how the merge, stall and idle-completion cases are shown to create nothing.

// File: rtl/walk_mshr_pkg.sv
package walk_mshr_pkg;
    localparam int unsigned DEF_SLOTS  = 4;
    localparam int unsigned DEF_REQS   = 16;
    localparam int unsigned DEF_VPN_W  = 36;
    localparam int unsigned DEF_ASID_W = 12;
endpackage

// File: rtl/walk_mshr_match.sv
module walk_mshr_match #(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned VPN_W     = 36,
    parameter int unsigned ASID_W    = 12
) (
    input  logic [NUM_SLOTS-1:0]             busy_i,
    input  logic [NUM_SLOTS-1:0][VPN_W-1:0]  vpn_i,
    input  logic [NUM_SLOTS-1:0][ASID_W-1:0] asid_i,
    input  logic [VPN_W-1:0]                 key_vpn_i,
    input  logic [ASID_W-1:0]                key_asid_i,
    output logic [NUM_SLOTS-1:0]             hit_o
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
        assign hit_o[s] = busy_i[s] && (vpn_i[s] == key_vpn_i) && (asid_i[s] == key_asid_i);
    end
endmodule

// File: rtl/walk_mshr_pick.sv
module walk_mshr_pick #(
    parameter int unsigned NUM_SLOTS = 4,
    localparam int unsigned SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] free_i,
    output logic                 found_o,
    output logic [SLOT_W-1:0]    idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (free_i[s]) begin
                found_o = 1'b1;
                idx_o   = SLOT_W'(s);
            end
        end
    end

    always_comb begin
        if (found_o) begin
            assert_pick_free_R10: assert (free_i[idx_o]);
        end
    end
endmodule

// File: rtl/walk_mshr.sv
module walk_mshr
    import walk_mshr_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = DEF_SLOTS,
    parameter int unsigned NUM_REQ   = DEF_REQS,
    parameter int unsigned VPN_W     = DEF_VPN_W,
    parameter int unsigned ASID_W    = DEF_ASID_W,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
    localparam int unsigned RID_W    = $clog2(NUM_REQ)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              miss_valid_i,
    output logic              miss_ready_o,
    input  logic [RID_W-1:0]  miss_rid_i,
    input  logic [VPN_W-1:0]  miss_vpn_i,
    input  logic [ASID_W-1:0] miss_asid_i,
    output logic              walk_start_valid_o,
    output logic [SLOT_W-1:0] walk_start_slot_o,
    output logic [VPN_W-1:0]  walk_start_vpn_o,
    output logic [ASID_W-1:0] walk_start_asid_o,
    input  logic              walk_done_valid_i,
    input  logic [SLOT_W-1:0] walk_done_slot_i,
    output logic              wake_valid_o,
    output logic [NUM_REQ-1:0] wake_mask_o
);
    typedef struct packed {
        logic               busy;
        logic [VPN_W-1:0]   vpn;
        logic [ASID_W-1:0]  asid;
        logic [NUM_REQ-1:0] waiters;
    } slot_t;

    typedef struct packed {
        slot_t [NUM_SLOTS-1:0] slot;
        logic                  start_v;
        logic [SLOT_W-1:0]     start_idx;
        logic [VPN_W-1:0]      start_vpn;
        logic [ASID_W-1:0]     start_asid;
        logic                  wake_v;
        logic [NUM_REQ-1:0]    wake_mask;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_SLOTS-1:0]             busy_vec;
    logic [NUM_SLOTS-1:0][VPN_W-1:0]  vpn_vec;
    logic [NUM_SLOTS-1:0][ASID_W-1:0] asid_vec;
    logic [NUM_SLOTS-1:0]             hit_raw, hit_eff, done_sel;
    logic                             free_found;
    logic [SLOT_W-1:0]                free_idx;
    logic                             accept, done_live;
    logic [NUM_REQ-1:0]               rid_oh;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_view
        assign busy_vec[s] = state_q.slot[s].busy;
        assign vpn_vec[s]  = state_q.slot[s].vpn;
        assign asid_vec[s] = state_q.slot[s].asid;
        assign done_sel[s] = walk_done_valid_i && (walk_done_slot_i == SLOT_W'(s));
    end

    walk_mshr_match #(.NUM_SLOTS(NUM_SLOTS), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
        .busy_i     (busy_vec),
        .vpn_i      (vpn_vec),
        .asid_i     (asid_vec),
        .key_vpn_i  (miss_vpn_i),
        .key_asid_i (miss_asid_i),
        .hit_o      (hit_raw)
    );

    walk_mshr_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
        .free_i  (~busy_vec),
        .found_o (free_found),
        .idx_o   (free_idx)
    );

    // a walk finishing this cycle no longer accepts new waiters
    assign hit_eff      = hit_raw & ~done_sel;
    assign miss_ready_o = free_found;
    assign accept       = miss_valid_i && miss_ready_o;
    assign done_live    = walk_done_valid_i && state_q.slot[walk_done_slot_i].busy;
    assign rid_oh       = NUM_REQ'(1) << miss_rid_i;

    always_comb begin
        state_d           = state_q;
        state_d.start_v   = 1'b0;
        state_d.wake_v    = 1'b0;
        state_d.wake_mask = '0;

        if (done_live) begin
            state_d.wake_v    = 1'b1;
            state_d.wake_mask = state_q.slot[walk_done_slot_i].waiters;
            state_d.slot[walk_done_slot_i] = '0;
        end

        if (accept) begin
            if (|hit_eff) begin
                for (int s = 0; s < NUM_SLOTS; s++) begin
                    if (hit_eff[s]) begin
                        state_d.slot[s].waiters = state_q.slot[s].waiters | rid_oh;
                    end
                end
            end else begin
                state_d.slot[free_idx].busy    = 1'b1;
                state_d.slot[free_idx].vpn     = miss_vpn_i;
                state_d.slot[free_idx].asid    = miss_asid_i;
                state_d.slot[free_idx].waiters = rid_oh;
                state_d.start_v    = 1'b1;
                state_d.start_idx  = free_idx;
                state_d.start_vpn  = miss_vpn_i;
                state_d.start_asid = miss_asid_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign walk_start_valid_o = state_q.start_v;
    assign walk_start_slot_o  = state_q.start_idx;
    assign walk_start_vpn_o   = state_q.start_vpn;
    assign walk_start_asid_o  = state_q.start_asid;
    assign wake_valid_o       = state_q.wake_v;
    assign wake_mask_o        = state_q.wake_mask;

    assert_stall_no_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (miss_valid_i && !miss_ready_o) |=> !walk_start_valid_o);

    assert_merge_no_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && (|hit_eff)) |=> !walk_start_valid_o);

    assert_unique_key_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(hit_raw));

    assert_wake_nonempty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_valid_o |-> (|wake_mask_o));

    assert_idle_done_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (walk_done_valid_i && !busy_vec[walk_done_slot_i]) |=> !wake_valid_o);

    assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!accept) |=> !walk_start_valid_o);
endmodule

// File: tb/tb_walk_mshr.sv
module tb_walk_mshr;
    localparam int unsigned NS = 4, NR = 16, VW = 36, AW = 12;
    localparam int unsigned SW = 2, RW = 4;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic          miss_ready;
    logic [RW-1:0] miss_rid = '0;
    logic [VW-1:0] miss_vpn = '0;
    logic [AW-1:0] miss_asid = '0;
    logic          start_v;
    logic [SW-1:0] start_slot;
    logic [VW-1:0] start_vpn;
    logic [AW-1:0] start_asid;
    logic          done_v = 1'b0;
    logic [SW-1:0] done_slot = '0;
    logic          wake_v;
    logic [NR-1:0] wake_mask;

    always #5 clk = ~clk;

    walk_mshr dut (
        .clk_i(clk), .rst_ni(rst_n),
        .miss_valid_i(miss_valid), .miss_ready_o(miss_ready),
        .miss_rid_i(miss_rid), .miss_vpn_i(miss_vpn), .miss_asid_i(miss_asid),
        .walk_start_valid_o(start_v), .walk_start_slot_o(start_slot),
        .walk_start_vpn_o(start_vpn), .walk_start_asid_o(start_asid),
        .walk_done_valid_i(done_v), .walk_done_slot_i(done_slot),
        .wake_valid_o(wake_v), .wake_mask_o(wake_mask)
    );

    int compared = 0, mismatched = 0;
    bit finished = 1'b0;
    logic [SW+VW+AW-1:0] exp_start_q[$];
    logic [NR-1:0]       exp_wake_q[$];
    string               start_tag_q[$];
    string               wake_tag_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pop and compare each result pulse
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (start_v) begin
                if (exp_start_q.size() == 0)
                    check(1'b0, "R3", "unexpected walk start", {start_slot, start_asid}, 64'h0);
                else begin
                    automatic logic [SW+VW+AW-1:0] e = exp_start_q.pop_front();
                    automatic string t = start_tag_q.pop_front();
                    check({start_slot, start_vpn, start_asid} == e, t, "walk start",
                          64'({start_slot, start_vpn, start_asid}), 64'(e));
                end
            end
            if (wake_v) begin
                if (exp_wake_q.size() == 0)
                    check(1'b0, "R9", "unexpected wake", 64'(wake_mask), 64'h0);
                else begin
                    automatic logic [NR-1:0] e = exp_wake_q.pop_front();
                    automatic string t = wake_tag_q.pop_front();
                    check(wake_mask == e, t, "wake mask", 64'(wake_mask), 64'(e));
                end
            end
        end
    end

    task automatic miss(input int rid, input logic [VW-1:0] vpn, input logic [AW-1:0] asid,
                        input bit new_walk, input int slot, input string tag);
        @(posedge clk); #1;
        miss_valid = 1'b1; miss_rid = RW'(rid); miss_vpn = vpn; miss_asid = asid;
        if (new_walk) begin
            exp_start_q.push_back({SW'(slot), vpn, asid});
            start_tag_q.push_back(tag);
        end
        @(posedge clk); #1;
        miss_valid = 1'b0;
    endtask

    task automatic finish_walk(input int slot, input bit expect_wake, input logic [NR-1:0] mask,
                               input string tag);
        @(posedge clk); #1;
        done_v = 1'b1; done_slot = SW'(slot);
        if (expect_wake) begin
            exp_wake_q.push_back(mask);
            wake_tag_q.push_back(tag);
        end
        @(posedge clk); #1;
        done_v = 1'b0;
    endtask

    localparam logic [VW-1:0] PA = 36'h1_2345_6000, PB = 36'h0_00AB_C000;
    localparam logic [VW-1:0] PC = 36'h7_FFFF_F000, PD = 36'h0_0000_1000;

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            compared++; mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(miss_ready == 1'b1, "R1", "ready after reset", 64'(miss_ready), 64'h1);
        check(start_v == 1'b0, "R1", "start after reset", 64'(start_v), 64'h0);
        check(wake_v == 1'b0, "R1", "wake after reset", 64'(wake_v), 64'h0);

        miss(1, PA, 12'h001, 1'b1, 0, "R2");   // R2, R10: slot 0 first
        miss(2, PA, 12'h001, 1'b0, 0, "R3");   // R3: merges
        miss(3, PA, 12'h002, 1'b1, 1, "R4");   // R4: other address space
        miss(4, PB, 12'h001, 1'b1, 2, "R10");
        miss(5, PC, 12'h001, 1'b1, 3, "R10");
        @(negedge clk);
        check(miss_ready == 1'b0, "R5", "ready when full", 64'(miss_ready), 64'h0);

        // R5: a miss held while full must not start anything
        @(posedge clk); #1;
        miss_valid = 1'b1; miss_rid = 4'd6; miss_vpn = PD; miss_asid = 12'h001;
        repeat (3) @(posedge clk);
        #1 miss_valid = 1'b0;
        @(negedge clk);
        check(miss_ready == 1'b0, "R5", "ready still low", 64'(miss_ready), 64'h0);

        // R6: release both waiters of slot 0
        finish_walk(0, 1'b1, 16'h0006, "R6");
        @(negedge clk);
        check(miss_ready == 1'b1, "R5", "ready after free", 64'(miss_ready), 64'h1);
        miss(7, PD, 12'h001, 1'b1, 0, "R10");

        finish_walk(1, 1'b1, 16'h0008, "R6");

        // R7: miss to PB in the same cycle PB's walk completes
        @(posedge clk); #1;
        done_v = 1'b1; done_slot = 2'd2;
        miss_valid = 1'b1; miss_rid = 4'd8; miss_vpn = PB; miss_asid = 12'h001;
        exp_wake_q.push_back(16'h0010); wake_tag_q.push_back("R7");
        exp_start_q.push_back({2'd1, PB, 12'h001}); start_tag_q.push_back("R7");
        @(posedge clk); #1;
        done_v = 1'b0; miss_valid = 1'b0;

        // R8: PC freed, then missed again -> new walk, lowest free is slot 2
        finish_walk(3, 1'b1, 16'h0020, "R8");
        miss(9, PC, 12'h001, 1'b1, 2, "R8");
        miss(10, PC, 12'h001, 1'b0, 2, "R3");

        // R9: completion on free slot 3
        finish_walk(3, 1'b0, 16'h0000, "R9");
        @(negedge clk);
        check(wake_v == 1'b0, "R9", "no wake on idle slot", 64'(wake_v), 64'h0);

        // merged waiters of slot 2 (requesters 9 and 10)
        finish_walk(2, 1'b1, 16'h0600, "R6");
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(exp_start_q.size() == 0, "R2", "pending starts", 64'(exp_start_q.size()), 64'h0);
        check(exp_wake_q.size() == 0, "R6", "pending wakes", 64'(exp_wake_q.size()), 64'h0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule